// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block collects event pulses from the receive, transmit, statistics and remote-DMA logic of a network controller. It keeps them as sticky bits in an 8-bit status register and raises one interrupt line while any event that software has enabled is pending. Software reads the status and the 7-bit enable mask through a small register port. It acknowledges an event by writing a one to that event's bit.

Bit 7 of the status register is not a latched event. It is a read-only level that reports whether the controller is halted. A stop command or a ring overwrite sets it. A start command or the removal of a frame from the receive ring clears it. The enable mask has no bit for it, so it never raises the interrupt.

Top module: `intStatusUnit`

## Requirements
- R1: After reset the status register reads 0x80, the mask reads 0x00 and `irqOut` is low.
- R2: Status bit positions are as follows. Bit 0 is good receive (`rxOkPulse`), bit 1 is good transmit (`txOkPulse`), bit 4 is ring overwrite (`ovwPulse`) and bit 6 is remote DMA done (`dmaDonePulse`). A pulse sampled at a clock edge sets its bit, and the new value is visible after that edge.
- R3: Status bit 2 is set when any bit of `rxErrCause` is high. The causes are CRC, alignment, FIFO overrun and missed frame. Status bit 3 is set when any bit of `txErrCause` is high. The causes are excess collisions and FIFO underrun.
- R4: Status bit 5 is set on the edge at which any bit of `tallyMsb` goes from 0 to 1. A counter MSB that stays high does not set it again.
- R5: A write to address 0 clears each of status bits 0 to 6 whose data bit is 1. Bits written as 0 keep their value, and status bit 7 ignores all writes.
- R6: When an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R7: Address 1 holds the mask. Mask bits 0 to 6 are written from `regWdata[6:0]`, and bit 7 always reads 0. `regRdata` shows the register that `regAddr` selects, with no clock delay.
- R8: `irqOut` is a register. After each edge it equals the OR, taken before that edge, of status bits 0 to 6 ANDed with the mask.
- R9: Status bit 7 is set by `stopCmd` or `ovwPulse` and cleared by `startCmd` or `frameRemoved`. When a set and a clear arrive together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxOkPulse | input | 1 | Frame received without error |
| txOkPulse | input | 1 | Frame transmitted without error |
| rxErrCause | input | 4 | Receive error causes |
| txErrCause | input | 2 | Transmit error causes |
| ovwPulse | input | 1 | Receive ring overwrite |
| tallyMsb | input | 3 | MSB levels of the error tally counters |
| dmaDonePulse | input | 1 | Remote DMA complete |
| stopCmd | input | 1 | Stop command issued |
| startCmd | input | 1 | Start command issued |
| frameRemoved | input | 1 | A frame was taken out of the receive ring |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects status, 1 selects mask |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register |
| irqOut | output | 1 | Interrupt request level |

## Verification
The assertions assume that event and command inputs are clean single-cycle levels sampled at the clock edge. They also assume that a clear write and a pulse that does not target the same bit are independent. The assertions make no assumption about how often events occur, so back-to-back pulses and simultaneous set and clear are legal. The stimulus drives every input one time unit after the rising edge and holds it for a full cycle. Random phases mix all of the event sources with register writes to both addresses, including same-cycle event and clear collisions.

// File: rtl/intStatusPkg.sv
package intStatusPkg;
  localparam int EVT_N = 7;
  localparam int DATA_W = EVT_N + 1;
  localparam int BIT_RXOK = 0;
  localparam int BIT_TXOK = 1;
  localparam int BIT_RXERR = 2;
  localparam int BIT_TXERR = 3;
  localparam int BIT_OVW = 4;
  localparam int BIT_CNT = 5;
  localparam int BIT_DMA = 6;

  typedef struct packed {
    logic [EVT_N-1:0] evtSet;
    logic [EVT_N-1:0] evtClr;
    logic             maskWr;
    logic [EVT_N-1:0] maskData;
    logic             haltSet;
    logic             haltClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/intStatusCtrl.sv
module intStatusCtrl
  import intStatusPkg::*;
#(
  parameter int RX_CAUSES = 4,
  parameter int TX_CAUSES = 2,
  parameter int TALLY_N = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxOkPulse,
  input  logic                 txOkPulse,
  input  logic [RX_CAUSES-1:0] rxErrCause,
  input  logic [TX_CAUSES-1:0] txErrCause,
  input  logic                 ovwPulse,
  input  logic [TALLY_N-1:0]   tallyMsb,
  input  logic                 dmaDonePulse,
  input  logic                 stopCmd,
  input  logic                 startCmd,
  input  logic                 frameRemoved,
  input  logic                 regWr,
  input  logic                 regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output ctrlStrobe_t          strobe
);
  logic [TALLY_N-1:0] msbPrev;
  logic [TALLY_N-1:0] msbRise;

  // one rising-edge detector per tally counter
  for (genvar i = 0; i < TALLY_N; i++) begin : g_tally
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) msbPrev[i] <= 1'b0;
      else       msbPrev[i] <= tallyMsb[i];
    end
    assign msbRise[i] = tallyMsb[i] & ~msbPrev[i];
  end

  always_comb begin
    strobe = '0;
    strobe.evtSet[BIT_RXOK]  = rxOkPulse;
    strobe.evtSet[BIT_TXOK]  = txOkPulse;
    strobe.evtSet[BIT_RXERR] = |rxErrCause;
    strobe.evtSet[BIT_TXERR] = |txErrCause;
    strobe.evtSet[BIT_OVW]   = ovwPulse;
    strobe.evtSet[BIT_CNT]   = |msbRise;
    strobe.evtSet[BIT_DMA]   = dmaDonePulse;
    strobe.evtClr   = (regWr && !regAddr) ? regWdata[EVT_N-1:0] : '0;
    strobe.maskWr   = regWr && regAddr;
    strobe.maskData = regWdata[EVT_N-1:0];
    strobe.haltSet  = stopCmd | ovwPulse;
    strobe.haltClr  = startCmd | frameRemoved;
  end
endmodule

// File: rtl/intStatusDatapath.sv
module intStatusDatapath
  import intStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              regAddr,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] maskReg,
  output logic              irqOut
);
  logic [EVT_N-1:0] evtQ;
  logic [EVT_N-1:0] maskQ;
  logic             haltQ;

  for (genvar b = 0; b < EVT_N; b++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtQ[b] <= 1'b0;
      else       evtQ[b] <= (evtQ[b] & ~strobe.evtClr[b]) | strobe.evtSet[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ <= 1'b1;
      maskQ <= '0;
      irqOut <= 1'b0;
    end else begin
      if (strobe.haltSet)      haltQ <= 1'b1;
      else if (strobe.haltClr) haltQ <= 1'b0;
      if (strobe.maskWr) maskQ <= strobe.maskData;
      irqOut <= |(evtQ & maskQ);
    end
  end

  assign statusReg = {haltQ, evtQ};
  assign maskReg   = {1'b0, maskQ};
  assign regRdata  = regAddr ? maskReg : statusReg;
endmodule

// File: rtl/intStatusUnit.sv
module intStatusUnit
  import intStatusPkg::*;
#(
  parameter int RX_CAUSES = 4,
  parameter int TX_CAUSES = 2,
  parameter int TALLY_N = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxOkPulse,
  input  logic                 txOkPulse,
  input  logic [RX_CAUSES-1:0] rxErrCause,
  input  logic [TX_CAUSES-1:0] txErrCause,
  input  logic                 ovwPulse,
  input  logic [TALLY_N-1:0]   tallyMsb,
  input  logic                 dmaDonePulse,
  input  logic                 stopCmd,
  input  logic                 startCmd,
  input  logic                 frameRemoved,
  input  logic                 regWr,
  input  logic                 regAddr,
  input  logic [7:0]           regWdata,
  output logic [7:0]           regRdata,
  output logic                 irqOut
);
  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] statusReg;
  logic [DATA_W-1:0] maskReg;

  intStatusCtrl #(
    .RX_CAUSES(RX_CAUSES), .TX_CAUSES(TX_CAUSES), .TALLY_N(TALLY_N)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rxOkPulse(rxOkPulse), .txOkPulse(txOkPulse),
    .rxErrCause(rxErrCause), .txErrCause(txErrCause), .ovwPulse(ovwPulse),
    .tallyMsb(tallyMsb), .dmaDonePulse(dmaDonePulse), .stopCmd(stopCmd),
    .startCmd(startCmd), .frameRemoved(frameRemoved), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .strobe(strobe)
  );

  intStatusDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regRdata(regRdata), .statusReg(statusReg), .maskReg(maskReg),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/intStatusChk.sv
module intStatusChk #(
  parameter int RX_CAUSES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rxOkPulse,
  input logic                 txOkPulse,
  input logic [RX_CAUSES-1:0] rxErrCause,
  input logic                 ovwPulse,
  input logic                 stopCmd,
  input logic                 regWr,
  input logic                 regAddr,
  input logic [7:0]           regWdata,
  input logic [7:0]           regRdata,
  input logic [7:0]           statusReg,
  input logic [7:0]           maskReg,
  input logic                 irqOut
);
  logic clrWr;
  assign clrWr = regWr && !regAddr;

  AST_RXOK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rxOkPulse |=> statusReg[0]); // R2
  AST_RXERR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|rxErrCause) |=> statusReg[2]); // R3
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && regWdata[0] && !rxOkPulse) |=> !statusReg[0]); // R5
  AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[0] && !(clrWr && regWdata[0])) |=> statusReg[0]); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && regWdata[1] && txOkPulse) |=> statusReg[1]); // R6
  AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regAddr |-> !regRdata[7]); // R7
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusReg[6:0] & maskReg[6:0])) |=> irqOut); // R8
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusReg[6:0] & maskReg[6:0])) |=> !irqOut); // R8
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd || ovwPulse) |=> statusReg[7]); // R9
endmodule

bind intStatusUnit intStatusChk #(.RX_CAUSES(RX_CAUSES)) u_chk (
  .clk(clk), .rstN(rstN), .rxOkPulse(rxOkPulse), .txOkPulse(txOkPulse),
  .rxErrCause(rxErrCause), .ovwPulse(ovwPulse), .stopCmd(stopCmd),
  .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
  .regRdata(regRdata), .statusReg(statusReg), .maskReg(maskReg),
  .irqOut(irqOut)
);

// File: tb/intStatusUnit_tb.sv
`timescale 1ns/1ps
module intStatusUnit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxOkPulse = 0, txOkPulse = 0, ovwPulse = 0, dmaDonePulse = 0;
  logic [3:0] rxErrCause = '0;
  logic [1:0] txErrCause = '0;
  logic [2:0] tallyMsb = '0;
  logic stopCmd = 0, startCmd = 0, frameRemoved = 0;
  logic regWr = 0, regAddr = 0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic irqOut;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intStatusUnit u_dut (
    .clk(clk), .rstN(rstN), .rxOkPulse(rxOkPulse), .txOkPulse(txOkPulse),
    .rxErrCause(rxErrCause), .txErrCause(txErrCause), .ovwPulse(ovwPulse),
    .tallyMsb(tallyMsb), .dmaDonePulse(dmaDonePulse), .stopCmd(stopCmd),
    .startCmd(startCmd), .frameRemoved(frameRemoved), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqOut(irqOut)
  );

  // behavioural reference model
  bit [6:0] mEvt;
  bit       mHalt;
  bit [6:0] mMask;
  bit       mIrq;
  bit [2:0] mPrev;
  bit       mValid = 0;

  always @(posedge clk) begin
    bit [6:0] ev;
    bit [6:0] clr;
    bit nIrq;
    if (!rstN) begin
      mEvt = 0; mHalt = 1; mMask = 0; mIrq = 0; mPrev = 0; mValid = 1;
    end else begin
      nIrq = (mEvt & mMask) != 0;
      ev = {dmaDonePulse, (tallyMsb & ~mPrev) != 0, ovwPulse,
            txErrCause != 0, rxErrCause != 0, txOkPulse, rxOkPulse};
      clr = (regWr && !regAddr) ? regWdata[6:0] : 7'd0;
      mEvt = (mEvt & ~clr) | ev;
      if (stopCmd || ovwPulse) mHalt = 1;
      else if (startCmd || frameRemoved) mHalt = 0;
      if (regWr && regAddr) mMask = regWdata[6:0];
      mPrev = tallyMsb;
      mIrq = nIrq;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rstN && mValid) begin
      check(regAddr ? "R7" : "R2", regRdata,
            regAddr ? {1'b0, mMask} : {mHalt, mEvt});
      check("R8", {7'd0, irqOut}, {7'd0, mIrq});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    rxOkPulse = 0; txOkPulse = 0; ovwPulse = 0; dmaDonePulse = 0;
    rxErrCause = 0; txErrCause = 0; stopCmd = 0; startCmd = 0;
    frameRemoved = 0; regWr = 0; regWdata = 0;
  endtask

  task automatic rdChk(string tag, bit addr, logic [7:0] exp);
    regAddr = addr; #0.5;
    check(tag, regRdata, exp);
  endtask

  task automatic wr(bit addr, logic [7:0] d);
    regWr = 1; regAddr = addr; regWdata = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    // R1 reset values
    rdChk("R1", 0, 8'h80);
    rdChk("R1", 1, 8'h00);
    check("R1", {7'd0, irqOut}, 8'h00);
    rstN = 1; tick();
    rdChk("R1", 0, 8'h80);

    startCmd = 1; tick();
    rdChk("R9", 0, 8'h00);
    rxOkPulse = 1; tick();
    rdChk("R2", 0, 8'h01);
    dmaDonePulse = 1; tick();
    rdChk("R2", 0, 8'h41);
    ovwPulse = 1; tick();
    rdChk("R9", 0, 8'hD1);
    frameRemoved = 1; tick();
    rdChk("R9", 0, 8'h51);
    wr(0, 8'h51); tick();
    rdChk("R5", 0, 8'h00);

    // R3 each cause individually
    for (int i = 0; i < 4; i++) begin
      rxErrCause = 4'(1 << i); tick();
      rdChk("R3", 0, 8'h04);
      wr(0, 8'h04); tick();
    end
    for (int i = 0; i < 2; i++) begin
      txErrCause = 2'(1 << i); tick();
      rdChk("R3", 0, 8'h08);
      wr(0, 8'h08); tick();
    end

    // R4 edge detection on tally MSBs
    tallyMsb = 3'b010; tick();
    rdChk("R4", 0, 8'h20);
    wr(0, 8'h20); tick();
    tick();
    rdChk("R4", 0, 8'h00);
    tallyMsb = 3'b110; tick();
    rdChk("R4", 0, 8'h20);
    tallyMsb = 3'b000; wr(0, 8'h20); tick();

    // R5 writing zeros and bit 7
    txOkPulse = 1; rxOkPulse = 1; tick();
    wr(0, 8'h00); tick();
    rdChk("R5", 0, 8'h03);
    stopCmd = 1; tick();
    wr(0, 8'h81); tick();
    rdChk("R5", 0, 8'h82);
    startCmd = 1; tick();

    // R6 event wins over clear
    txOkPulse = 1; wr(0, 8'h02); tick();
    rdChk("R6", 0, 8'h02);

    // R7 mask storage
    wr(1, 8'hFF); tick();
    rdChk("R7", 1, 8'h7F);
    wr(1, 8'h00); tick();

    // R8 interrupt timing: bit1 pending, enable it
    wr(1, 8'h02); tick();
    check("R8", {7'd0, irqOut}, 8'h00);
    tick();
    check("R8", {7'd0, irqOut}, 8'h01);
    wr(0, 8'h02); tick();
    check("R8", {7'd0, irqOut}, 8'h01);
    tick();
    check("R8", {7'd0, irqOut}, 8'h00);

    // R9 set wins over clear
    stopCmd = 1; startCmd = 1; tick();
    rdChk("R9", 0, 8'h80);
    frameRemoved = 1; tick();
    rdChk("R9", 0, 8'h00);

    // random phase, compared cycle by cycle
    for (int c = 0; c < 3000; c++) begin
      rxOkPulse = ($urandom % 8) == 0;
      txOkPulse = ($urandom % 8) == 0;
      ovwPulse = ($urandom % 16) == 0;
      dmaDonePulse = ($urandom % 8) == 0;
      rxErrCause = (($urandom % 6) == 0) ? 4'($urandom) : 4'd0;
      txErrCause = (($urandom % 6) == 0) ? 2'($urandom) : 2'd0;
      if (($urandom % 10) == 0) tallyMsb = 3'($urandom);
      stopCmd = ($urandom % 16) == 0;
      startCmd = ($urandom % 12) == 0;
      frameRemoved = ($urandom % 12) == 0;
      regAddr = ($urandom % 4) == 0;
      regWr = ($urandom % 3) == 0;
      regWdata = 8'($urandom);
      @(posedge clk); #1;
    end
    tick();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule